// File: doc/BRIEF.md
# Gated battery status monitor

This block turns a raw, asynchronous battery condition level from an external sense circuit into one status bit and an interrupt request. The status bit does not follow the sense line continuously. It takes a new value only when the receiver enable signal goes from on to off. At that moment the supply is quiet, so the reading is not disturbed by the receiver's current draw.

A gating input works as a disable. When it is low, each receiver switch-off loads the synchronized battery level into the status bit. When it is high, the status bit keeps its value. Any change of the status bit, in either direction, raises an interrupt request. Because both directions raise it, a host can use a sense circuit of either polarity. The request stays high until the host pulses an acknowledge strobe.

Top module: `batt_status_monitor`

## Requirements
- R1: After reset `batt_stat_o` is 0 and `irq_o` is 0.
- R2: `batt_stat_o` can change only after a clock edge at which `rx_en_i` is low and was high at the previous edge. That edge is the falling-edge event. At that edge the status takes the sampled battery level, and the new value is visible right after it. Holding `rx_en_i` low, or raising it, never loads a sample.
- R3: A change of `batt_lvl_i` while no falling-edge event occurs leaves `batt_stat_o` and `irq_o` unchanged.
- R4: When `mon_dis_i` is 1 at a falling-edge event, `batt_stat_o` keeps its value and no interrupt is raised. When `mon_dis_i` is 0, the event loads the sample.
- R5: When a loaded sample differs from the previous status, `irq_o` is 1 after that same edge. This holds for a 0-to-1 change and for a 1-to-0 change.
- R6: When a loaded sample equals the current status, `irq_o` does not rise.
- R7: Once `irq_o` is 1, it stays 1 until a one-cycle high pulse on `irq_ack_i`. It is 0 after the edge that sees the acknowledge, unless R8 applies.
- R8: If a status change and an acknowledge fall on the same edge, `irq_o` stays 1.
- R9: `batt_lvl_i` passes through a two-flop synchronizer. A falling-edge event samples the level that was present two or more edges earlier. A level applied only one edge before the event is not captured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| batt_lvl_i | input | 1 | Raw battery condition from the sense circuit (asynchronous) |
| rx_en_i | input | 1 | Receiver enable; its on-to-off transition triggers a sample |
| mon_dis_i | input | 1 | Monitor gate; 1 stops status updates |
| irq_ack_i | input | 1 | One-cycle acknowledge that clears the interrupt request |
| batt_stat_o | output | 1 | Latched battery status bit |
| irq_o | output | 1 | Interrupt request, held until acknowledged |

## Verification
A new status change and a host acknowledge can land on the same clock edge. In that case the set must win over the clear. The bench leaves a request pending and presents a battery level opposite to the current status. It then drops the receiver enable in the same cycle as a single acknowledge pulse. After that edge the bench expects the new status and a request that is still high. A second, lone acknowledge must then clear the request.

// File: rtl/batt_mon_pkg.sv
package batt_mon_pkg;
  localparam int unsigned SYNC_STAGES_DEF = 2;
  localparam logic        STAT_RST_DEF    = 1'b0;
endpackage

// File: rtl/batt_mon_sync.sv
module batt_mon_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[i] <= 1'b0;
        else         chain_q[i] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[i] <= 1'b0;
        else         chain_q[i] <= chain_q[i-1];
      end
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/batt_mon_sampler.sv
module batt_mon_sampler #(
  parameter logic STAT_RST = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_en_i,
  input  logic mon_dis_i,
  input  logic batt_s_i,
  output logic stat_o,
  output logic chg_o
);
  logic rx_q;
  logic stat_q;
  logic rx_fall;
  logic load;

  // reset low so a receiver held off through reset does not sample
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rx_q <= 1'b0;
    else         rx_q <= rx_en_i;
  end

  assign rx_fall = rx_q & ~rx_en_i;
  assign load    = rx_fall & ~mon_dis_i;
  assign chg_o   = load & (batt_s_i ^ stat_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   stat_q <= STAT_RST;
    else if (load) stat_q <= batt_s_i;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/batt_mon_irq.sv
module batt_mon_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic ack_i,
  output logic irq_o
);
  logic irq_q;

  // set dominates acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    irq_q <= 1'b0;
    else if (set_i) irq_q <= 1'b1;
    else if (ack_i) irq_q <= 1'b0;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/batt_status_monitor.sv
module batt_status_monitor
  import batt_mon_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF,
  parameter logic        STAT_RST    = STAT_RST_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic batt_lvl_i,
  input  logic rx_en_i,
  input  logic mon_dis_i,
  input  logic irq_ack_i,
  output logic batt_stat_o,
  output logic irq_o
);
  logic batt_s;
  logic chg;

  batt_mon_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (batt_lvl_i),
    .q_o    (batt_s)
  );

  batt_mon_sampler #(.STAT_RST(STAT_RST)) u_sampler (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rx_en_i   (rx_en_i),
    .mon_dis_i (mon_dis_i),
    .batt_s_i  (batt_s),
    .stat_o    (batt_stat_o),
    .chg_o     (chg)
  );

  batt_mon_irq u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (chg),
    .ack_i  (irq_ack_i),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/batt_status_monitor_chk.sv
module batt_status_monitor_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic rx_en_i,
  input logic mon_dis_i,
  input logic irq_ack_i,
  input logic batt_stat_o,
  input logic irq_o
);
  logic rx_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rx_d <= 1'b0;
    else         rx_d <= rx_en_i;
  end

  assert_stat_only_on_fall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_d && !rx_en_i) |=> $stable(batt_stat_o));

  assert_gate_holds_stat_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_d && !rx_en_i && mon_dis_i) |=> $stable(batt_stat_o));

  assert_change_raises_irq_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(batt_stat_o) |-> irq_o);

  assert_irq_needs_change_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> !$stable(batt_stat_o));

  assert_irq_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_ack_i) |=> irq_o);

  assert_ack_clears_unless_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_i |=> (!irq_o || !$stable(batt_stat_o)));
endmodule

bind batt_status_monitor batt_status_monitor_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rx_en_i     (rx_en_i),
  .mon_dis_i   (mon_dis_i),
  .irq_ack_i   (irq_ack_i),
  .batt_stat_o (batt_stat_o),
  .irq_o       (irq_o)
);

// File: tb/batt_status_monitor_tb.sv
`timescale 1ns/1ps
module batt_status_monitor_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic batt = 1'b0, rx_en = 1'b1, dis = 1'b0, ack = 1'b0;
  logic stat, irq;
  int   n_chk = 0, n_err = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  batt_status_monitor u_dut (
    .clk_i(clk), .rst_ni(rst_n), .batt_lvl_i(batt), .rx_en_i(rx_en),
    .mon_dis_i(dis), .irq_ack_i(ack), .batt_stat_o(stat), .irq_o(irq)
  );

  // {batt, dis, exp_stat, exp_irq}
  localparam logic [3:0] VEC [8] = '{
    4'b1011,  // R5 rise
    4'b1010,  // R6 equal
    4'b0110,  // R4 gated
    4'b0001,  // R5 fall
    4'b0000,  // R6 equal
    4'b1100,  // R4 gated
    4'b1011,  // R5 rise
    4'b0001   // R5 fall
  };

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // drop receiver enable; returns after the sampling edge
  task automatic rx_off(input logic gate);
    dis = gate; rx_en = 1'b0;
    cyc(1);
  endtask

  task automatic rx_on();
    rx_en = 1'b1; dis = 1'b0;
    cyc(1);
  endtask

  task automatic pulse_ack();
    ack = 1'b1; cyc(1); ack = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    cyc(2);
    chk("R1 stat", stat, 1'b0);
    chk("R1 irq", irq, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    cyc(2);
    chk("R1 stat after release", stat, 1'b0);

    for (int v = 0; v < 8; v++) begin
      batt = VEC[v][3];
      cyc(3);
      rx_off(VEC[v][2]);
      chk($sformatf("R4/R5/R6 vec%0d stat", v), stat, VEC[v][1]);
      chk($sformatf("R5/R6 vec%0d irq", v), irq, VEC[v][0]);
      cyc(2);
      chk($sformatf("R7 vec%0d irq held", v), irq, VEC[v][0]);
      pulse_ack();
      cyc(1);
      chk($sformatf("R7 vec%0d irq cleared", v), irq, 1'b0);
      rx_on();
    end
    // stat is now 0, irq 0, rx_en high

    // R3/R2: toggle batt with rx held low, then raise rx
    batt = 1'b1; cyc(3);
    rx_off(1'b1);             // gated edge consumed
    dis = 1'b0;
    for (int i = 0; i < 6; i++) begin batt = ~batt; cyc(3); end
    chk("R3 stat while rx low", stat, 1'b0);
    chk("R3 irq while rx low", irq, 1'b0);
    batt = 1'b1; cyc(3);
    rx_on(); cyc(2);
    chk("R2 rising edge no sample", stat, 1'b0);
    chk("R2 rising edge no irq", irq, 1'b0);

    // R2: falling edge samples once
    rx_off(1'b0);
    chk("R2 fall samples", stat, 1'b1);
    batt = 1'b0; cyc(4);
    chk("R2 held low no resample", stat, 1'b1);
    pulse_ack(); cyc(1);
    rx_on();

    // R9: level changed one edge before the event is missed
    batt = 1'b0; cyc(3); // synced 0, stat 1
    batt = 1'b1; cyc(1);
    rx_off(1'b0);
    chk("R9 late level not captured", stat, 1'b0);
    chk("R9 irq on old level", irq, 1'b1);
    pulse_ack(); cyc(1);
    rx_on();

    // R8: change coincides with ack while request pending
    batt = 1'b1; cyc(3);
    rx_off(1'b0);           // stat 0->1, irq set
    chk("R8 setup irq", irq, 1'b1);
    rx_on();
    batt = 1'b0; cyc(3);
    ack = 1'b1; dis = 1'b0; rx_en = 1'b0;
    cyc(1);
    ack = 1'b0;
    chk("R8 stat", stat, 1'b0);
    chk("R8 irq kept", irq, 1'b1);
    pulse_ack(); cyc(1);
    chk("R7 lone ack clears", irq, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule